// File: doc/BRIEF.md
# Exception PC and Delay-Slot Tracker

This control unit sits at the retirement point of an in-order pipeline that has a single branch delay slot. Each cycle it may see one retiring instruction: its address, whether it is a branch, whether the branch was taken and where it goes, and whether the instruction raised a misaligned-access fault. It also sees two asynchronous request lines, one from a tick timer and one from an external interrupt controller. It decides whether an exception is accepted at this instruction boundary. On acceptance it saves the exception PC and a delay-slot flag, and it redirects fetch to a fixed vector for the cause.

By default, the instruction after a branch counts as a delay slot only when the branch was taken. While such a slot is outstanding, asynchronous requests wait until the slot instruction completes. The saved PC is then the branch target. A fault raised by the slot instruction itself saves the branch address and sets the flag. A build-time option selects a simpler policy in which the instruction after any branch, taken or not, is treated as a slot.

A return pulse redirects fetch to the saved PC. It leaves the saved state untouched.

Top module: `epc_dslot_unit`

## Requirements
- R1: After reset, `exc_flush` and `redirect` are 0, `epc` is 0, `epc_dsx` is 0 and `exc_cause` is 0.
- R2: A misaligned-access fault on the instruction retiring in the delay slot of a taken branch is accepted. In the next cycle `epc` equals that instruction's address minus 4 and `epc_dsx` is 1.
- R3: With the default policy, a fault on the instruction after a branch that was not taken (or after no branch) saves that instruction's own address, with `epc_dsx` 0.
- R4: An asynchronous request is not accepted at the retirement of a branch that opens a delay slot, nor while the slot is still outstanding. When the slot instruction retires without a fault, the request is accepted with `epc` equal to the branch target and `epc_dsx` 0.
- R5: An asynchronous request that meets an ordinary instruction retiring without a fault is accepted, with `epc` equal to that address plus 4 and `epc_dsx` 0. `epc_dsx` is only ever 1 together with cause code 1.
- R6: Priority and cause codes: an alignment fault (code 1) wins over tick (code 2), which wins over the external interrupt (code 3). Code 0 means no exception has been taken since reset.
- R7: Acceptance is reported one cycle later as a single-cycle `exc_flush` with `redirect` 1. `redirect_pc` is then 0x600 for an alignment fault, 0x500 for tick and 0x800 for an external interrupt.
- R8: `epc`, `epc_dsx` and `exc_cause` change only in the cycle after an accepted exception, and hold their values otherwise.
- R9: `restore_req` with no instruction retiring gives, one cycle later, `redirect` 1, `exc_flush` 0 and `redirect_pc` equal to `epc`. The saved state is unchanged.
- R10: With `SIMPLE_SLOT`=1, the instruction after a branch that was not taken is also a slot. A fault on it saves the branch address with `epc_dsx` 1. Asynchronous requests are held at the branch, and when accepted at the slot they save the branch address plus 8.
- R11: No exception is accepted in a cycle with no retiring instruction; requests wait for an instruction boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | AW | Address of the retiring instruction |
| ret_is_branch | input | 1 | Retiring instruction is a branch |
| ret_br_taken | input | 1 | That branch is taken |
| ret_br_target | input | AW | Branch target address |
| ret_align_fault | input | 1 | Retiring instruction raised a misaligned-access fault |
| tick_req | input | 1 | Tick timer request (level) |
| pic_req | input | 1 | External interrupt request (level) |
| restore_req | input | 1 | Return: redirect to the saved PC |
| exc_flush | output | 1 | One-cycle pipeline flush on acceptance |
| redirect | output | 1 | `redirect_pc` is valid this cycle |
| redirect_pc | output | AW | Vector address or restored PC |
| epc | output | AW | Saved exception PC |
| epc_dsx | output | 1 | Saved delay-slot flag |
| exc_cause | output | 2 | Cause of the last accepted exception |

## Verification
A wrong slot bit appears at the ports no later than the cycle after the next retirement. It shows as an `epc` that is off by one instruction in either direction, as a misplaced `epc_dsx`, or as an asynchronous request accepted at a branch when it should wait. A stale slot-successor register appears as an `epc` that is not the branch target. The sweep combines every predecessor kind (none, taken, not taken) with every mix of fault, tick and interrupt on the following instruction, under both policies. Each outcome is compared one cycle after the retirement, so a fault in the held state surfaces on the first scenario that uses it.

// File: rtl/epc_pkg.sv
package epc_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'd0,
      CAUSE_ALIGN = 2'd1,
      CAUSE_TICK  = 2'd2,
      CAUSE_EXT   = 2'd3
   } cause_e;

   localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/epc_slot_track.sv
module epc_slot_track #(
   parameter int unsigned AW          = 32,
   parameter bit          SIMPLE_SLOT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ret_valid,
   input  logic          ret_is_branch,
   input  logic          ret_br_taken,
   input  logic [AW-1:0] ret_pc,
   input  logic [AW-1:0] ret_br_target,
   input  logic          accept,
   input  logic          restore,
   output logic          opens_slot,
   output logic          slot_now,
   output logic [AW-1:0] slot_next_pc
);
   import epc_pkg::*;

   localparam logic [AW-1:0] SKIP2 = AW'(2 * INSN_BYTES);

   logic          slot_q;
   logic [AW-1:0] next_q;

   generate
      if (SIMPLE_SLOT) begin : g_any_branch
         assign opens_slot = ret_is_branch;
      end else begin : g_taken_only
         assign opens_slot = ret_is_branch & ret_br_taken;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= 1'b0;
         next_q <= '0;
      end else if (accept || restore) begin
         slot_q <= 1'b0;
      end else if (ret_valid) begin
         slot_q <= opens_slot;
         next_q <= ret_br_taken ? ret_br_target : ret_pc + SKIP2;
      end
   end

   assign slot_now     = slot_q;
   assign slot_next_pc = next_q;
endmodule

// File: rtl/epc_cause_arb.sv
module epc_cause_arb #(
   parameter int unsigned AW        = 32,
   parameter int unsigned VEC_TICK  = 32'h500,
   parameter int unsigned VEC_EXT   = 32'h800,
   parameter int unsigned VEC_ALIGN = 32'h600
) (
   input  logic             ret_valid,
   input  logic [AW-1:0]    ret_pc,
   input  logic             ret_align_fault,
   input  logic             tick_req,
   input  logic             pic_req,
   input  logic             opens_slot,
   input  logic             slot_now,
   input  logic [AW-1:0]    slot_next_pc,
   output logic             accept,
   output epc_pkg::cause_e  cause,
   output logic [AW-1:0]    vec,
   output logic [AW-1:0]    save_pc,
   output logic             save_dsx
);
   import epc_pkg::*;

   localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

   logic sync_hit;
   logic async_ok;

   assign sync_hit = ret_valid & ret_align_fault;
   assign async_ok = ret_valid & ~ret_align_fault & ~opens_slot;

   always_comb begin
      accept   = 1'b0;
      cause    = CAUSE_NONE;
      vec      = '0;
      save_pc  = '0;
      save_dsx = 1'b0;
      if (sync_hit) begin
         accept   = 1'b1;
         cause    = CAUSE_ALIGN;
         vec      = AW'(VEC_ALIGN);
         save_dsx = slot_now;
         save_pc  = slot_now ? ret_pc - STEP : ret_pc;
      end else if (async_ok && (tick_req || pic_req)) begin
         accept  = 1'b1;
         cause   = tick_req ? CAUSE_TICK : CAUSE_EXT;
         vec     = tick_req ? AW'(VEC_TICK) : AW'(VEC_EXT);
         save_pc = slot_now ? slot_next_pc : ret_pc + STEP;
      end
   end
endmodule

// File: rtl/epc_save_regs.sv
module epc_save_regs #(
   parameter int unsigned AW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  logic            restore,
   input  epc_pkg::cause_e cause,
   input  logic [AW-1:0]   vec,
   input  logic [AW-1:0]   save_pc,
   input  logic            save_dsx,
   output logic            flush,
   output logic            redirect,
   output logic [AW-1:0]   redirect_pc,
   output logic [AW-1:0]   epc,
   output logic            dsx,
   output epc_pkg::cause_e cause_q
);
   import epc_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush       <= 1'b0;
         redirect    <= 1'b0;
         redirect_pc <= '0;
         epc         <= '0;
         dsx         <= 1'b0;
         cause_q     <= CAUSE_NONE;
      end else if (accept) begin
         flush       <= 1'b1;
         redirect    <= 1'b1;
         redirect_pc <= vec;
         epc         <= save_pc;
         dsx         <= save_dsx;
         cause_q     <= cause;
      end else if (restore) begin
         flush       <= 1'b0;
         redirect    <= 1'b1;
         redirect_pc <= epc;
      end else begin
         flush    <= 1'b0;
         redirect <= 1'b0;
      end
   end
endmodule

// File: rtl/epc_dslot_unit.sv
module epc_dslot_unit #(
   parameter int unsigned AW          = 32,
   parameter bit          SIMPLE_SLOT = 1'b0,
   parameter int unsigned VEC_TICK    = 32'h500,
   parameter int unsigned VEC_EXT     = 32'h800,
   parameter int unsigned VEC_ALIGN   = 32'h600
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ret_valid,
   input  logic [AW-1:0] ret_pc,
   input  logic          ret_is_branch,
   input  logic          ret_br_taken,
   input  logic [AW-1:0] ret_br_target,
   input  logic          ret_align_fault,
   input  logic          tick_req,
   input  logic          pic_req,
   input  logic          restore_req,
   output logic          exc_flush,
   output logic          redirect,
   output logic [AW-1:0] redirect_pc,
   output logic [AW-1:0] epc,
   output logic          epc_dsx,
   output logic [1:0]    exc_cause
);
   import epc_pkg::*;

   localparam longint unsigned SPACE = 64'd1 << AW;

   generate
      if (AW < 12 || AW > 32) begin : g_bad_aw
         $error("epc_dslot_unit: AW must lie in 12..32");
      end
      if ((VEC_TICK % 4) != 0 || (VEC_EXT % 4) != 0 || (VEC_ALIGN % 4) != 0) begin : g_bad_align
         $error("epc_dslot_unit: vectors must be word aligned");
      end
      if (longint'(VEC_TICK) >= SPACE || longint'(VEC_EXT) >= SPACE ||
          longint'(VEC_ALIGN) >= SPACE) begin : g_bad_range
         $error("epc_dslot_unit: vector outside the address space");
      end
   endgenerate

   logic          accept;
   logic          opens_slot;
   logic          slot_now;
   logic [AW-1:0] slot_next_pc;
   cause_e        cause;
   cause_e        cause_q;
   logic [AW-1:0] vec;
   logic [AW-1:0] save_pc;
   logic          save_dsx;

   epc_slot_track #(.AW(AW), .SIMPLE_SLOT(SIMPLE_SLOT)) u_slot (
      .clk           (clk),
      .rst_n         (rst_n),
      .ret_valid     (ret_valid),
      .ret_is_branch (ret_is_branch),
      .ret_br_taken  (ret_br_taken),
      .ret_pc        (ret_pc),
      .ret_br_target (ret_br_target),
      .accept        (accept),
      .restore       (restore_req),
      .opens_slot    (opens_slot),
      .slot_now      (slot_now),
      .slot_next_pc  (slot_next_pc)
   );

   epc_cause_arb #(.AW(AW), .VEC_TICK(VEC_TICK), .VEC_EXT(VEC_EXT),
                   .VEC_ALIGN(VEC_ALIGN)) u_arb (
      .ret_valid       (ret_valid),
      .ret_pc          (ret_pc),
      .ret_align_fault (ret_align_fault),
      .tick_req        (tick_req),
      .pic_req         (pic_req),
      .opens_slot      (opens_slot),
      .slot_now        (slot_now),
      .slot_next_pc    (slot_next_pc),
      .accept          (accept),
      .cause           (cause),
      .vec             (vec),
      .save_pc         (save_pc),
      .save_dsx        (save_dsx)
   );

   epc_save_regs #(.AW(AW)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .restore     (restore_req),
      .cause       (cause),
      .vec         (vec),
      .save_pc     (save_pc),
      .save_dsx    (save_dsx),
      .flush       (exc_flush),
      .redirect    (redirect),
      .redirect_pc (redirect_pc),
      .epc         (epc),
      .dsx         (epc_dsx),
      .cause_q     (cause_q)
   );

   assign exc_cause = cause_q;
endmodule

// File: rtl/epc_dslot_unit_chk.sv
module epc_dslot_unit_chk #(
   parameter int unsigned AW          = 32,
   parameter bit          SIMPLE_SLOT = 1'b0,
   parameter int unsigned VEC_TICK    = 32'h500,
   parameter int unsigned VEC_EXT     = 32'h800,
   parameter int unsigned VEC_ALIGN   = 32'h600
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ret_valid,
   input logic          ret_is_branch,
   input logic          ret_br_taken,
   input logic          ret_align_fault,
   input logic          restore_req,
   input logic          exc_flush,
   input logic          redirect,
   input logic [AW-1:0] redirect_pc,
   input logic [AW-1:0] epc,
   input logic          epc_dsx,
   input logic [1:0]    exc_cause
);
   // R8: saved PC moves only on a reported acceptance
   p_epc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_flush |-> ($stable(epc) && $stable(epc_dsx)));

   // R5: delay-slot flag only accompanies a synchronous fault
   p_dsx_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_flush && epc_dsx) |-> (exc_cause == 2'd1));

   // R7: vector matches the cause
   p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_flush |-> (redirect && redirect_pc ==
         ((exc_cause == 2'd1) ? AW'(VEC_ALIGN) :
          (exc_cause == 2'd2) ? AW'(VEC_TICK) : AW'(VEC_EXT))));

   // R4 / R10: no asynchronous acceptance at a slot-opening branch
   p_hold_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && ret_is_branch && (ret_br_taken || SIMPLE_SLOT) && !ret_align_fault)
      |=> !exc_flush);

   // R11: acceptance only at an instruction boundary
   p_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ret_valid |=> !exc_flush);

   // R6: a fault always wins
   p_fault_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && ret_align_fault) |=> (exc_flush && exc_cause == 2'd1));

   // R9: return redirects to the saved PC
   p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_req && !ret_valid) |=> (redirect && !exc_flush && redirect_pc == $past(epc)));
endmodule

bind epc_dslot_unit epc_dslot_unit_chk #(
   .AW(AW), .SIMPLE_SLOT(SIMPLE_SLOT), .VEC_TICK(VEC_TICK),
   .VEC_EXT(VEC_EXT), .VEC_ALIGN(VEC_ALIGN)
) u_chk (.*);

// File: tb/epc_dslot_unit_test.sv
`timescale 1ns/1ps
module epc_dslot_unit_test;
   localparam int AW = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n;
   logic          ret_valid;
   logic [AW-1:0] ret_pc;
   logic          ret_is_branch;
   logic          ret_br_taken;
   logic [AW-1:0] ret_br_target;
   logic          ret_align_fault;
   logic          tick_req;
   logic          pic_req;
   logic          restore_req;

   logic          flush_d, redir_d, dsx_d;
   logic [AW-1:0] rpc_d, epc_d;
   logic [1:0]    cause_d;
   logic          flush_s, redir_s, dsx_s;
   logic [AW-1:0] rpc_s, epc_s;
   logic [1:0]    cause_s;

   epc_dslot_unit #(.AW(AW), .SIMPLE_SLOT(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
      .ret_is_branch(ret_is_branch), .ret_br_taken(ret_br_taken),
      .ret_br_target(ret_br_target), .ret_align_fault(ret_align_fault),
      .tick_req(tick_req), .pic_req(pic_req), .restore_req(restore_req),
      .exc_flush(flush_d), .redirect(redir_d), .redirect_pc(rpc_d),
      .epc(epc_d), .epc_dsx(dsx_d), .exc_cause(cause_d));

   epc_dslot_unit #(.AW(AW), .SIMPLE_SLOT(1'b1)) uut_s (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
      .ret_is_branch(ret_is_branch), .ret_br_taken(ret_br_taken),
      .ret_br_target(ret_br_target), .ret_align_fault(ret_align_fault),
      .tick_req(tick_req), .pic_req(pic_req), .restore_req(restore_req),
      .exc_flush(flush_s), .redirect(redir_s), .redirect_pc(rpc_s),
      .epc(epc_s), .epc_dsx(dsx_s), .exc_cause(cause_s));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [AW-1:0] exp_epc [2];
   logic          exp_dsx [2];
   logic [1:0]    exp_cause [2];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_in();
      ret_valid = 0; ret_pc = '0; ret_is_branch = 0; ret_br_taken = 0;
      ret_br_target = '0; ret_align_fault = 0; tick_req = 0; pic_req = 0;
      restore_req = 0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [AW-1:0] vec_of(logic [1:0] c);
      return (c == 2'd1) ? AW'(16'h600) : (c == 2'd2) ? AW'(16'h500) : AW'(16'h800);
   endfunction

   // outcome check for one instance; s=0 default policy, s=1 simplified policy
   task automatic check_out(int s, bit take, logic [1:0] c, logic [AW-1:0] pc,
                            bit dsx, string tag);
      logic fl, dx;
      logic [AW-1:0] ep, rp;
      logic [1:0] ca;
      fl = (s == 0) ? flush_d : flush_s;
      dx = (s == 0) ? dsx_d   : dsx_s;
      ep = (s == 0) ? epc_d   : epc_s;
      rp = (s == 0) ? rpc_d   : rpc_s;
      ca = (s == 0) ? cause_d : cause_s;
      if (take) begin
         exp_epc[s] = pc; exp_dsx[s] = dsx; exp_cause[s] = c;
      end
      chk($sformatf("%s flush uut%0d", tag, s), 32'(fl), 32'(take));
      chk($sformatf("%s epc uut%0d", tag, s), 32'(ep), 32'(exp_epc[s]));
      chk($sformatf("%s dsx uut%0d", tag, s), 32'(dx), 32'(exp_dsx[s]));
      chk($sformatf("%s cause uut%0d", tag, s), 32'(ca), 32'(exp_cause[s]));
      if (take) chk($sformatf("%s R7 vector uut%0d", tag, s), 32'(rp), 32'(vec_of(c)));
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R11 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      clear_in();
      rst_n = 0;
      for (int i = 0; i < 2; i++) begin
         exp_epc[i] = '0; exp_dsx[i] = 0; exp_cause[i] = 2'd0;
      end
      repeat (3) step();
      rst_n = 1;
      step();
      // R1 reset state
      chk("R1 redirect uut0", 32'(redir_d), 0);
      chk("R1 redirect uut1", 32'(redir_s), 0);
      check_out(0, 0, 0, 0, 0, "R1");
      check_out(1, 0, 0, 0, 0, "R1");

      // sweep: predecessor kind x fault x tick x pic, both policies (R2 R3 R5 R6 R10)
      for (int kind = 0; kind < 3; kind++) begin
         for (int combo = 0; combo < 8; combo++) begin
            logic [AW-1:0] p, tgt;
            bit f, t, q;
            f = combo[2]; t = combo[1]; q = combo[0];
            p   = AW'(16'h1000 + (kind * 8 + combo) * 16'h40);
            tgt = AW'(16'h4000 + (kind * 8 + combo) * 16'h20);
            clear_in();
            ret_valid = 1; ret_pc = p; ret_is_branch = (kind != 0);
            ret_br_taken = (kind == 1); ret_br_target = tgt;
            step();
            check_out(0, 0, 0, 0, 0, "R11 predecessor");
            check_out(1, 0, 0, 0, 0, "R11 predecessor");
            clear_in();
            ret_valid = 1; ret_pc = p + 16'd4; ret_align_fault = f;
            tick_req = t; pic_req = q;
            step();
            for (int s = 0; s < 2; s++) begin
               bit slot;
               bit take;
               logic [1:0] c;
               logic [AW-1:0] pc;
               string tag;
               slot = (kind == 1) || (s == 1 && kind == 2);
               take = f || t || q;
               c  = f ? 2'd1 : t ? 2'd2 : 2'd3;
               if (f) pc = slot ? p : p + 16'd4;
               else   pc = (slot && kind == 1) ? tgt : p + 16'd8;
               tag = f ? (slot ? ((s == 1 && kind == 2) ? "R10 fault" : "R2 fault")
                               : "R3 fault")
                       : ((t || q) ? (slot ? "R4 slot async" : "R5 async") : "R8 idle");
               check_out(s, take, c, pc, f && slot, $sformatf("%s R6 k%0d c%0d", tag, kind, combo));
            end
            clear_in();
            step();
            chk("R7 single flush uut0", 32'(flush_d), 0);
            chk("R7 single flush uut1", 32'(flush_s), 0);
         end
      end

      // R4 R11: request held over a taken branch and an empty cycle
      clear_in();
      ret_valid = 1; ret_pc = 16'h3000; ret_is_branch = 1; ret_br_taken = 1;
      ret_br_target = 16'h3400; tick_req = 1; pic_req = 1;
      step();
      check_out(0, 0, 0, 0, 0, "R4 hold at branch");
      check_out(1, 0, 0, 0, 0, "R4 hold at branch");
      clear_in(); tick_req = 1;
      step();
      check_out(0, 0, 0, 0, 0, "R11 no boundary");
      check_out(1, 0, 0, 0, 0, "R11 no boundary");
      ret_valid = 1; ret_pc = 16'h3004;
      step();
      check_out(0, 1, 2'd2, 16'h3400, 0, "R4 slot done");
      check_out(1, 1, 2'd2, 16'h3400, 0, "R4 slot done");
      clear_in();
      step();

      // R10 vs R5: request at a branch that is not taken
      ret_valid = 1; ret_pc = 16'h3800; ret_is_branch = 1; ret_br_taken = 0;
      ret_br_target = 16'h3c00; tick_req = 1;
      step();
      check_out(0, 1, 2'd2, 16'h3804, 0, "R5 untaken branch");
      check_out(1, 0, 0, 0, 0, "R10 hold untaken");
      clear_in();
      step();
      ret_valid = 1; ret_pc = 16'h3804; tick_req = 1;
      step();
      check_out(0, 1, 2'd2, 16'h3808, 0, "R5 ordinary");
      check_out(1, 1, 2'd2, 16'h3808, 0, "R10 slot done");
      clear_in();
      step();

      // R9 restore
      restore_req = 1;
      step();
      chk("R9 redirect uut0", 32'(redir_d), 1);
      chk("R9 flush uut0", 32'(flush_d), 0);
      chk("R9 pc uut0", 32'(rpc_d), 32'(exp_epc[0]));
      chk("R9 redirect uut1", 32'(redir_s), 1);
      chk("R9 pc uut1", 32'(rpc_s), 32'(exp_epc[1]));
      clear_in();
      step();
      chk("R9 redirect ends", 32'(redir_d), 0);
      check_out(0, 0, 0, 0, 0, "R8 after restore");
      check_out(1, 0, 0, 0, 0, "R8 after restore");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule